// File: doc/BRIEF.md
# System Reset Source Controller

This block merges every reset request in the chip into one synchronous internal reset with a timed release. It takes four inputs. The first is a power-good comparator flag that clears all of the block's own state asynchronously. The second is a brown-out comparator flag. The third is a single-cycle watchdog expiry pulse. The fourth is the active-low external reset pin, which arrives asynchronously. Reset is released only after a release counter has run its full length with no request present. A brown-out always goes through the same full release delay as a power-up.

A per-chip option input chooses what a watchdog expiry does. When it is set, and the operating mode allows it, the expiry resets the chip. Otherwise the expiry produces an interrupt pulse. Four exclusive sticky flags record which source caused the most recent reset. Software reads them once the chip is running and clears them with a strobe.

The state machine has three states. `ST_HOLD` means a level request (brown-out or qualified pin) is active. `ST_COUNT` means the release counter is running. `ST_RUN` means reset is released. Its transitions are:
- `hold_to_count`: no level request is present.
- `count_to_hold` and `run_to_hold`: a level request appears.
- `count_to_run`: the counter is done.
- `run_to_count`: a watchdog reset is taken.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `por_low_i` is high, `sys_rst_o` is 1 and `status_o` is 0. When no other request is present, `sys_rst_o` falls on the RELEASE_CYCLES+1-th rising edge after `por_low_i` falls. `status_o` then reads 4'b0001.
- R2: `bod_low_i` sampled high at an edge makes `sys_rst_o` 1 after that edge. After `bod_low_i` is sampled low, release comes on the RELEASE_CYCLES+1-th edge. This is the full delay, never a shortened one.
- R3: The pin goes through PIN_SYNC_STAGES flops and then a low-run counter. It qualifies only when sampled low on at least PIN_MIN_LOW consecutive edges; any shorter low pulse has no effect on `sys_rst_o`. After a qualifying low ends, `sys_rst_o` falls PIN_SYNC_STAGES+2+RELEASE_CYCLES edges after the pin is first sampled high.
- R4: A `wdog_expire_i` pulse while running, with `wdog_act_rst_i`=1 and `wdog_mode_ok_i`=1, raises `sys_rst_o` after that edge. Release follows RELEASE_CYCLES edges later.
- R5: A `wdog_expire_i` pulse while running, with `wdog_act_rst_i`=0 or `wdog_mode_ok_i`=0, leaves `sys_rst_o` low. It gives `wdog_irq_o`=1 for exactly the one cycle after that edge.
- R6: `wdog_irq_o` is never 1 while `sys_rst_o` is 1. An expiry that arrives during reset is ignored: it produces neither an interrupt nor a change of cause.
- R7: If a request reappears while the release counter runs, the counter restarts from zero. Release then takes the full delay after the new request clears.
- R8: `status_o` is one-hot: bit 0 power-on, bit 1 brown-out, bit 2 watchdog, bit 3 external pin. On release, the bit for the most recent cause is set. When both are active in the same cycle, brown-out takes priority over the pin.
- R9: `status_clr_i`=1 at an edge clears `status_o`. At the release edge, setting the new cause takes priority over clearing.
- R10: `status_o` changes only at a release edge or on a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_low_i | input | 1 | Supply below power-on threshold; asynchronous reset of the block, active high |
| bod_low_i | input | 1 | Supply below brown-out threshold, synchronous to clk |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| wdog_expire_i | input | 1 | Watchdog expiry, single-cycle pulse |
| wdog_act_rst_i | input | 1 | 1: expiry resets the chip; 0: expiry raises an interrupt |
| wdog_mode_ok_i | input | 1 | 1 when the operating mode allows a watchdog reset |
| status_clr_i | input | 1 | Clears the cause flags |
| sys_rst_o | output | 1 | Internal system reset, active high |
| wdog_irq_o | output | 1 | Watchdog interrupt pulse |
| status_o | output | 4 | One-hot cause of the last reset |

## Verification
The checker makes three assumptions about the inputs:
- `wdog_expire_i` is a single-cycle pulse.
- `bod_low_i` is already synchronous to `clk`.
- `por_low_i` falls away from a rising edge.

The bench keeps within these assumptions by driving every input at the falling edge and raising the expiry for exactly one cycle. It sweeps the pin low time, all four watchdog option and mode pairs, and every restart point inside the release window. The expected release edges are derived from RELEASE_CYCLES and the synchronizer depth.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;

    typedef enum logic [1:0] {
        CAUSE_POR   = 2'd0,
        CAUSE_BROWN = 2'd1,
        CAUSE_WDOG  = 2'd2,
        CAUSE_PIN   = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_COUNT = 2'd1,
        ST_RUN   = 2'd2
    } rst_state_e;

    localparam int CAUSE_N = 4;

endpackage

// File: rtl/rst_pin_qualify.sv
module rst_pin_qualify #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 4
) (
    input  logic clk,
    input  logic arst_i,
    input  logic pin_n_i,
    output logic req_o
);
    localparam int CW = $clog2(MIN_LOW + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          low_cnt_q;

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) sync_q[0] <= 1'b1;
        else        sync_q[0] <= pin_n_i;
    end

    generate
        for (genvar g = 1; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or posedge arst_i) begin
                if (arst_i) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i)                         low_cnt_q <= '0;
        else if (sync_q[SYNC_STAGES-1])     low_cnt_q <= '0;
        else if (low_cnt_q != CW'(MIN_LOW)) low_cnt_q <= low_cnt_q + 1'b1;
    end

    assign req_o = (low_cnt_q == CW'(MIN_LOW));
endmodule

// File: rtl/rst_release_timer.sv
module rst_release_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic arst_i,
    input  logic clear_i,
    output logic done_o
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i)       cnt_q <= '0;
        else if (clear_i) cnt_q <= '0;
        else if (!done_o) cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/rst_wdog_route.sv
module rst_wdog_route (
    input  logic clk,
    input  logic arst_i,
    input  logic expire_i,
    input  logic act_rst_i,
    input  logic mode_ok_i,
    input  logic running_i,
    output logic take_rst_o,
    output logic irq_o
);
    logic hit;
    logic irq_q;

    assign hit        = expire_i & running_i;
    assign take_rst_o = hit & act_rst_i & mode_ok_i;

    always_ff @(posedge clk or posedge arst_i) begin
        if (arst_i) irq_q <= 1'b0;
        else        irq_q <= hit & ~(act_rst_i & mode_ok_i);
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rst_src_pkg::*;
#(
    parameter int RELEASE_CYCLES  = 64,
    parameter int PIN_MIN_LOW     = 4,
    parameter int PIN_SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 por_low_i,
    input  logic                 bod_low_i,
    input  logic                 ext_rst_n_i,
    input  logic                 wdog_expire_i,
    input  logic                 wdog_act_rst_i,
    input  logic                 wdog_mode_ok_i,
    input  logic                 status_clr_i,
    output logic                 sys_rst_o,
    output logic                 wdog_irq_o,
    output logic [CAUSE_N-1:0]   status_o
);
    rst_state_e          state_q, state_d;
    cause_e              cause_q, cause_d;
    logic [CAUSE_N-1:0]  status_q;
    logic                pin_req;
    logic                level_req;
    logic                running;
    logic                take_rst;
    logic                timer_done;
    logic                release_now;

    rst_pin_qualify #(
        .SYNC_STAGES (PIN_SYNC_STAGES),
        .MIN_LOW     (PIN_MIN_LOW)
    ) u_pin (
        .clk     (clk),
        .arst_i  (por_low_i),
        .pin_n_i (ext_rst_n_i),
        .req_o   (pin_req)
    );

    rst_release_timer #(
        .CYCLES (RELEASE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .arst_i  (por_low_i),
        .clear_i (state_q != ST_COUNT),
        .done_o  (timer_done)
    );

    assign level_req = bod_low_i | pin_req;
    assign running   = (state_q == ST_RUN) & ~level_req;

    rst_wdog_route u_wdog (
        .clk        (clk),
        .arst_i     (por_low_i),
        .expire_i   (wdog_expire_i),
        .act_rst_i  (wdog_act_rst_i),
        .mode_ok_i  (wdog_mode_ok_i),
        .running_i  (running),
        .take_rst_o (take_rst),
        .irq_o      (wdog_irq_o)
    );

    // Next-state logic: hold_to_count, count_to_hold, count_to_run,
    // run_to_hold, run_to_count.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (!level_req)     state_d = ST_COUNT;
            ST_COUNT: if (level_req)      state_d = ST_HOLD;
                      else if (timer_done) state_d = ST_RUN;
            ST_RUN:   if (level_req)      state_d = ST_HOLD;
                      else if (take_rst)  state_d = ST_COUNT;
            default:                      state_d = ST_HOLD;
        endcase
    end

    always_comb begin
        cause_d = cause_q;
        if (bod_low_i)     cause_d = CAUSE_BROWN;
        else if (pin_req)  cause_d = CAUSE_PIN;
        else if (take_rst) cause_d = CAUSE_WDOG;
    end

    assign release_now = (state_q == ST_COUNT) && (state_d == ST_RUN);

    always_ff @(posedge clk or posedge por_low_i) begin
        if (por_low_i) begin
            state_q <= ST_HOLD;
            cause_q <= CAUSE_POR;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_ff @(posedge clk or posedge por_low_i) begin
        if (por_low_i)         status_q <= '0;
        else if (release_now)  status_q <= CAUSE_N'(1) << cause_q;
        else if (status_clr_i) status_q <= '0;
    end

    // Output process
    always_comb begin
        sys_rst_o = (state_q != ST_RUN);
        status_o  = status_q;
    end
endmodule

// File: rtl/rst_src_ctrl_chk.sv
module rst_src_ctrl_chk (
    input logic       clk,
    input logic       por_low_i,
    input logic       bod_low_i,
    input logic       wdog_expire_i,
    input logic       wdog_act_rst_i,
    input logic       wdog_mode_ok_i,
    input logic       sys_rst_o,
    input logic       wdog_irq_o,
    input logic [3:0] status_o
);
    assert_bod_holds_R2: assert property (@(posedge clk) disable iff (por_low_i)
        bod_low_i |=> sys_rst_o);

    assert_no_release_in_bod_R2: assert property (@(posedge clk) disable iff (por_low_i)
        $fell(sys_rst_o) |-> !$past(bod_low_i));

    assert_wdog_reset_R4: assert property (@(posedge clk) disable iff (por_low_i)
        (wdog_expire_i && wdog_act_rst_i && wdog_mode_ok_i && !sys_rst_o) |=> sys_rst_o);

    assert_irq_single_R5: assert property (@(posedge clk) disable iff (por_low_i)
        wdog_irq_o |=> !wdog_irq_o);

    assert_irq_source_R5: assert property (@(posedge clk) disable iff (por_low_i)
        wdog_irq_o |-> $past(wdog_expire_i));

    assert_irq_not_in_reset_R6: assert property (@(posedge clk) disable iff (por_low_i)
        wdog_irq_o |-> !sys_rst_o);

    assert_status_onehot_R8: assert property (@(posedge clk) disable iff (por_low_i)
        $onehot0(status_o));

    assert_status_moves_R10: assert property (@(posedge clk) disable iff (por_low_i)
        !$stable(status_o) |-> ($fell(sys_rst_o) || status_o == 4'b0000));
endmodule

bind rst_src_ctrl rst_src_ctrl_chk u_chk (
    .clk            (clk),
    .por_low_i      (por_low_i),
    .bod_low_i      (bod_low_i),
    .wdog_expire_i  (wdog_expire_i),
    .wdog_act_rst_i (wdog_act_rst_i),
    .wdog_mode_ok_i (wdog_mode_ok_i),
    .sys_rst_o      (sys_rst_o),
    .wdog_irq_o     (wdog_irq_o),
    .status_o       (status_o)
);

// File: tb/rst_src_ctrl_bench.sv
module rst_src_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int REL        = 8;
    localparam int PMIN       = 4;
    localparam int PSYNC      = 2;

    logic       clk = 1'b0;
    logic       por_low, bod_low, pin_n, expire, act, mode_ok, clr;
    logic       sys_rst, irq;
    logic [3:0] status;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_src_ctrl #(
        .RELEASE_CYCLES  (REL),
        .PIN_MIN_LOW     (PMIN),
        .PIN_SYNC_STAGES (PSYNC)
    ) u_rst_src_ctrl (
        .clk            (clk),
        .por_low_i      (por_low),
        .bod_low_i      (bod_low),
        .ext_rst_n_i    (pin_n),
        .wdog_expire_i  (expire),
        .wdog_act_rst_i (act),
        .wdog_mode_ok_i (mode_ok),
        .status_clr_i   (clr),
        .sys_rst_o      (sys_rst),
        .wdog_irq_o     (irq),
        .status_o       (status)
    );

    task automatic chk(input string req, input int act_v, input int exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic observe(input int max, output int rise, output int fall);
        rise = sys_rst ? 0 : -1;
        fall = -1;
        for (int i = 1; i <= max; i++) begin
            @(negedge clk);
            if (sys_rst && rise < 0) rise = i;
            if (!sys_rst && rise >= 0 && fall < 0) fall = i;
        end
    endtask

    task automatic report();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        int rise, fall, prev;
        por_low = 1; bod_low = 0; pin_n = 1; expire = 0;
        act = 1; mode_ok = 1; clr = 0;
        step(3);
        chk("R1 reset sys_rst", sys_rst, 1);
        chk("R1 reset status", status, 0);
        chk("R1 reset irq", irq, 0);

        // R1: power-on release
        por_low = 0;
        observe(REL + 6, rise, fall);
        chk("R1 release edge", fall, REL + 1);
        chk("R1 por cause", status, 1);

        // R2: brown-out full delay
        bod_low = 1;
        step(1);
        chk("R2 bod asserts", sys_rst, 1);
        step(4);
        bod_low = 0;
        observe(REL + 6, rise, fall);
        chk("R2 bod release edge", fall, REL + 1);
        chk("R8 bod cause", status, 2);

        // R4/R5: watchdog option x mode sweep
        for (int a = 0; a < 2; a++) begin
            for (int m = 0; m < 2; m++) begin
                int want_rst;
                prev = status;
                act = a[0]; mode_ok = m[0];
                want_rst = a & m;
                expire = 1;
                step(1);
                expire = 0;
                chk("R4 wdog reset", sys_rst, want_rst);
                chk("R5 wdog irq", irq, 1 - want_rst);
                step(1);
                chk("R5 irq single cycle", irq, 0);
                if (want_rst != 0) begin
                    observe(REL + 6, rise, fall);
                    chk("R4 wdog release edge", fall, REL - 1);
                    chk("R8 wdog cause", status, 4);
                end else begin
                    chk("R10 status kept on irq", status, prev);
                end
            end
        end

        // R6: expiry during reset ignored
        act = 0;
        bod_low = 1;
        step(2);
        expire = 1;
        step(1);
        expire = 0;
        chk("R6 no irq in reset", irq, 0);
        step(1);
        chk("R6 no irq later", irq, 0);
        act = 1;
        expire = 1;
        step(1);
        expire = 0;
        bod_low = 0;
        observe(REL + 6, rise, fall);
        chk("R6 release edge", fall, REL + 1);
        chk("R6 cause unchanged", status, 2);

        // R3: pin low-duration sweep
        for (int d = 1; d <= 8; d++) begin
            prev = status;
            pin_n = 0;
            step(d);
            pin_n = 1;
            observe(REL + 12, rise, fall);
            if (d < PMIN) begin
                chk("R3 short pulse ignored", rise, -1);
                chk("R10 status kept", status, prev);
            end else begin
                chk("R3 rise edge", rise, (PSYNC + PMIN + 1 - d > 0) ? PSYNC + PMIN + 1 - d : 0);
                chk("R3 release edge", fall, PSYNC + 2 + REL);
                chk("R8 pin cause", status, 8);
            end
        end

        // R7: restart at every point of the release window
        for (int m = 0; m < REL; m++) begin
            bod_low = 1;
            step(2);
            bod_low = 0;
            step(m + 1);
            chk("R7 still counting", sys_rst, 1);
            bod_low = 1;
            step(1);
            bod_low = 0;
            observe(REL + 6, rise, fall);
            chk("R7 restart release edge", fall, REL + 1);
        end

        // R8: priority and most-recent cause
        bod_low = 1; pin_n = 0;
        step(8);
        pin_n = 1;
        step(4);
        bod_low = 0;
        observe(REL + 6, rise, fall);
        chk("R8 bod last release", fall, REL + 1);
        chk("R8 bod last cause", status, 2);
        bod_low = 1; pin_n = 0;
        step(8);
        bod_low = 0;
        step(3);
        pin_n = 1;
        observe(REL + 10, rise, fall);
        chk("R8 pin last release", fall, PSYNC + 2 + REL);
        chk("R8 pin last cause", status, 8);

        // R9: clear, and set over clear at release
        clr = 1;
        step(1);
        clr = 0;
        chk("R9 clear", status, 0);
        bod_low = 1;
        step(2);
        clr = 1;
        bod_low = 0;
        step(REL);
        chk("R9 counting", sys_rst, 1);
        chk("R9 cleared in reset", status, 0);
        step(1);
        clr = 0;
        chk("R9 released", sys_rst, 0);
        chk("R9 set wins", status, 2);
        step(1);
        chk("R9 flag stays", status, 2);

        report();
    end
endmodule